// File: doc/BRIEF.md
# Clock-synthesiser divisor search engine

This block looks for a set of divisors for a clock synthesiser whose output frequency hits a requested pixel clock, or lands just above it. A pixel clock in hertz is presented on `pix_hz` together with a one-cycle `start`. The engine first picks a post-multiplier (1, 2 or 4) from the pixel clock and forms the search target as the pixel clock times that multiplier. It then walks the divisor space (pre-divider n, two feedback divisors m1 and m2, post-divider p1, with a fixed second post-divider of 10) against a fixed 96 MHz reference. Each candidate's derived frequencies come from an internal multi-cycle restoring divider.

Every candidate must pass range checks on each divisor, on the combined feedback value, on the combined post-divider, on the oscillator frequency and on the output frequency. An exact hit ends the search at once. Otherwise the closest legal candidate strictly above the target is kept. When the walk ends, `done` pulses for one cycle and the result outputs (divisors, multiplier, a packed divisor word and the achieved frequency) are updated. They then hold until the next search completes.

Top module: `pll_div_search`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `valid` and `err` are 0 and every result output (`mult_o`, `n_o`, `m1_o`, `m2_o`, `p1_o`, `div_word`, `found_hz`) is 0.
- R2: `start` is accepted only when `busy` is 0. `busy` is 1 in the cycle after acceptance and stays 1 until the done cycle. `pix_hz` is sampled only at acceptance, and a `start` or a change of `pix_hz` while busy does not affect the result or produce an extra `done`.
- R3: On a search with a valid result, `mult_o` is 1 for a pixel clock of at least 100 000 000 Hz, 2 for at least 50 000 000 Hz, and 4 below that. The target is `pix_hz` times `mult_o`.
- R4: A pixel clock below 25 000 000 Hz ends the request with `err`=1, `valid`=0 and all other result outputs 0.
- R5: With M = 5*m1 + m2, P = p1*10, VCO = floor(96e6*M/n) and OUT = floor(VCO/P), a candidate is legal only if n is in 3..8, m1 in 10..20, m2 in 5..9, p1 in 1..8, m1 > m2, M is in 70..120, P is in 5..80, VCO is in 1.4e9..2.8e9 and OUT is in 2e7..4e8 (bounds inclusive). Reported divisors are always legal.
- R6: Candidates are visited with n ascending (outermost), then m1 descending, then m2 descending, then p1 descending (innermost). The first legal candidate whose OUT equals the target is reported.
- R7: Without an exact hit, the reported candidate is the legal one with OUT above the target and the smallest OUT minus target. A later candidate replaces the kept one only if its difference is strictly smaller, starting from a kept difference of 0xFFFFFFFF.
- R8: If no legal candidate has OUT at or above the target, `valid`=0, `err`=0 and all divisor outputs, `div_word` and `found_hz` are 0, while `mult_o` still shows the chosen multiplier.
- R9: When `valid`=1, `div_word` holds m2-2 in bits 7:0, m1-2 in bits 15:8 and n-2 in bits 23:16.
- R10: When `valid`=1, `found_hz` equals OUT of the reported divisors.
- R11: `done` is a single-cycle pulse with `busy`=0 in that cycle. The result outputs change only in a done cycle and hold their values until the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a search (taken when idle) |
| pix_hz | input | 32 | Requested pixel clock in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| valid | output | 1 | A usable divisor set was found |
| err | output | 1 | Pixel clock below the supported floor |
| mult_o | output | 3 | Chosen post-multiplier (1, 2 or 4) |
| n_o | output | 8 | Pre-divider n |
| m1_o | output | 8 | Feedback divisor m1 |
| m2_o | output | 8 | Feedback divisor m2 |
| p1_o | output | 8 | Post-divider p1 |
| div_word | output | 24 | Packed divisor word |
| found_hz | output | 32 | Output frequency of the chosen divisors |

## Verification
A fault in the walk order or the loop bounds shows up as a different divisor set from the bench's own search, visible at `n_o`, `m1_o`, `m2_o` and `p1_o` on the next `done`. A wrong divider step or range test moves `found_hz` or flips `valid` for targets near the edges of the oscillator and output ranges. A stuck control state shows at once as a missing or doubled `done` pulse or as `busy` staying high. Results are checked on every `done` against the bench's search. Multiplier boundaries, the sub-floor error, a target above every reachable frequency and a start issued mid-search are each run as separate scenarios.

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int FW      = 32,
  parameter int DW      = 8,
  parameter int DIV_W   = 40,
  parameter int DIV_BPC = 4,
  parameter logic [DIV_W-1:0] REF_HZ  = 40'd96_000_000,
  parameter int P2      = 10,
  parameter int N_MIN   = 3,
  parameter int N_MAX   = 8,
  parameter int M1_MIN  = 10,
  parameter int M1_MAX  = 20,
  parameter int M2_MIN  = 5,
  parameter int M2_MAX  = 9,
  parameter int M_MIN   = 70,
  parameter int M_MAX   = 120,
  parameter int P1_MIN  = 1,
  parameter int P1_MAX  = 8,
  parameter int P_MIN   = 5,
  parameter int P_MAX   = 80,
  parameter logic [DIV_W-1:0] VCO_MIN = 40'd1_400_000_000,
  parameter logic [DIV_W-1:0] VCO_MAX = 40'd2_800_000_000,
  parameter logic [DIV_W-1:0] OUT_MIN = 40'd20_000_000,
  parameter logic [DIV_W-1:0] OUT_MAX = 40'd400_000_000,
  parameter logic [FW-1:0] PIX_FLOOR = 32'd25_000_000,
  parameter logic [FW-1:0] PIX_MID   = 32'd50_000_000,
  parameter logic [FW-1:0] PIX_HIGH  = 32'd100_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [FW-1:0]   pix_hz,
  output logic            busy,
  output logic            done,
  output logic            valid,
  output logic            err,
  output logic [2:0]      mult_o,
  output logic [DW-1:0]   n_o,
  output logic [DW-1:0]   m1_o,
  output logic [DW-1:0]   m2_o,
  output logic [DW-1:0]   p1_o,
  output logic [3*DW-1:0] div_word,
  output logic [FW-1:0]   found_hz
);

  localparam int DIV_CYC = DIV_W / DIV_BPC;
  localparam int CW      = $clog2(DIV_CYC + 1);
  localparam int MW      = DW + 4;
  localparam logic [DW-1:0] L_N_MIN  = DW'(N_MIN);
  localparam logic [DW-1:0] L_N_MAX  = DW'(N_MAX);
  localparam logic [DW-1:0] L_M1_MIN = DW'(M1_MIN);
  localparam logic [DW-1:0] L_M1_MAX = DW'(M1_MAX);
  localparam logic [DW-1:0] L_M2_MIN = DW'(M2_MIN);
  localparam logic [DW-1:0] L_M2_MAX = DW'(M2_MAX);
  localparam logic [DW-1:0] L_P1_MIN = DW'(P1_MIN);
  localparam logic [DW-1:0] L_P1_MAX = DW'(P1_MAX);
  localparam logic [DW-1:0] TWO      = DW'(2);

  typedef enum logic [2:0] {
    S_IDLE, S_CHKM, S_VDIV, S_PCHK, S_DDIV, S_NXTP, S_NXTM, S_FIN
  } state_t;

  state_t          state;
  logic [FW-1:0]   tgt;
  logic [2:0]      mult_r;
  logic            low_r;
  logic [DW-1:0]   cn, cm1, cm2, cp1;
  logic [DIV_W-1:0] vco_r;
  logic [FW-1:0]   best_diff;
  logic            have_best;
  logic [DW-1:0]   bn, bm1, bm2, bp1;
  logic [FW-1:0]   bhz;

  logic [DIV_W:0]   d_rem;
  logic [DIV_W-1:0] d_quo;
  logic [DIV_W-1:0] d_den;
  logic [CW-1:0]    d_cnt;
  logic [DIV_W:0]   st_rem;
  logic [DIV_W-1:0] st_quo;

  logic [2:0]      mult_sel;
  logic [MW-1:0]   cand_m, p_val;
  logic            m_ok, p_ok, vco_ok, out_ok, hit, better;
  logic [DIV_W-1:0] tgt_w, diff;

  assign busy = (state != S_IDLE);

  always_comb begin
    if (pix_hz >= PIX_HIGH)     mult_sel = 3'd1;
    else if (pix_hz >= PIX_MID) mult_sel = 3'd2;
    else                        mult_sel = 3'd4;
  end

  assign cand_m = MW'(5) * MW'(cm1) + MW'(cm2);
  assign p_val  = MW'(cp1) * MW'(P2);
  assign m_ok   = (cm1 > cm2) && (cand_m >= MW'(M_MIN)) && (cand_m <= MW'(M_MAX));
  assign p_ok   = (p_val >= MW'(P_MIN)) && (p_val <= MW'(P_MAX));
  assign vco_ok = (d_quo >= VCO_MIN) && (d_quo <= VCO_MAX);
  assign out_ok = (d_quo >= OUT_MIN) && (d_quo <= OUT_MAX);
  assign tgt_w  = DIV_W'(tgt);
  assign diff   = d_quo - tgt_w;
  assign hit    = (d_quo == tgt_w);
  assign better = (d_quo > tgt_w) && (diff < DIV_W'(best_diff));

  always_comb begin
    st_rem = d_rem;
    st_quo = d_quo;
    for (int i = 0; i < DIV_BPC; i++) begin
      st_rem = {st_rem[DIV_W-1:0], st_quo[DIV_W-1]};
      st_quo = {st_quo[DIV_W-2:0], 1'b0};
      if (st_rem >= {1'b0, d_den}) begin
        st_rem    = st_rem - {1'b0, d_den};
        st_quo[0] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tgt       <= '0;
      mult_r    <= '0;
      low_r     <= 1'b0;
      cn        <= '0;
      cm1       <= '0;
      cm2       <= '0;
      cp1       <= '0;
      vco_r     <= '0;
      best_diff <= '1;
      have_best <= 1'b0;
      bn        <= '0;
      bm1       <= '0;
      bm2       <= '0;
      bp1       <= '0;
      bhz       <= '0;
      d_rem     <= '0;
      d_quo     <= '0;
      d_den     <= '0;
      d_cnt     <= '0;
      done      <= 1'b0;
      valid     <= 1'b0;
      err       <= 1'b0;
      mult_o    <= '0;
      n_o       <= '0;
      m1_o      <= '0;
      m2_o      <= '0;
      p1_o      <= '0;
      div_word  <= '0;
      found_hz  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          tgt       <= pix_hz * FW'(mult_sel);
          mult_r    <= mult_sel;
          low_r     <= (pix_hz < PIX_FLOOR);
          cn        <= L_N_MIN;
          cm1       <= L_M1_MAX;
          cm2       <= L_M2_MAX;
          best_diff <= '1;
          have_best <= 1'b0;
          state     <= (pix_hz < PIX_FLOOR) ? S_FIN : S_CHKM;
        end
        S_CHKM: begin
          if (m_ok) begin
            d_rem <= '0;
            d_quo <= REF_HZ * DIV_W'(cand_m);
            d_den <= DIV_W'(cn);
            d_cnt <= CW'(DIV_CYC);
            state <= S_VDIV;
          end else begin
            state <= S_NXTM;
          end
        end
        S_VDIV: begin
          if (d_cnt != '0) begin
            d_rem <= st_rem;
            d_quo <= st_quo;
            d_cnt <= d_cnt - CW'(1);
          end else if (vco_ok) begin
            vco_r <= d_quo;
            cp1   <= L_P1_MAX;
            state <= S_PCHK;
          end else begin
            state <= S_NXTM;
          end
        end
        S_PCHK: begin
          if (p_ok) begin
            d_rem <= '0;
            d_quo <= vco_r;
            d_den <= DIV_W'(p_val);
            d_cnt <= CW'(DIV_CYC);
            state <= S_DDIV;
          end else begin
            state <= S_NXTP;
          end
        end
        S_DDIV: begin
          if (d_cnt != '0) begin
            d_rem <= st_rem;
            d_quo <= st_quo;
            d_cnt <= d_cnt - CW'(1);
          end else begin
            state <= S_NXTP;
            if (out_ok && (hit || better)) begin
              bn        <= cn;
              bm1       <= cm1;
              bm2       <= cm2;
              bp1       <= cp1;
              bhz       <= FW'(d_quo);
              best_diff <= FW'(diff);
              have_best <= 1'b1;
              if (hit) state <= S_FIN;
            end
          end
        end
        S_NXTP: begin
          if (cp1 == L_P1_MIN) begin
            state <= S_NXTM;
          end else begin
            cp1   <= cp1 - DW'(1);
            state <= S_PCHK;
          end
        end
        S_NXTM: begin
          state <= S_CHKM;
          if (cm2 != L_M2_MIN) begin
            cm2 <= cm2 - DW'(1);
          end else begin
            cm2 <= L_M2_MAX;
            if (cm1 != L_M1_MIN) begin
              cm1 <= cm1 - DW'(1);
            end else begin
              cm1 <= L_M1_MAX;
              if (cn != L_N_MAX) cn <= cn + DW'(1);
              else state <= S_FIN;
            end
          end
        end
        S_FIN: begin
          done   <= 1'b1;
          err    <= low_r;
          valid  <= have_best && !low_r;
          mult_o <= low_r ? 3'd0 : mult_r;
          if (have_best && !low_r) begin
            n_o      <= bn;
            m1_o     <= bm1;
            m2_o     <= bm2;
            p1_o     <= bp1;
            div_word <= {bn - TWO, bm1 - TWO, bm2 - TWO};
            found_hz <= bhz;
          end else begin
            n_o      <= '0;
            m1_o     <= '0;
            m2_o     <= '0;
            p1_o     <= '0;
            div_word <= '0;
            found_hz <= '0;
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
  parameter int N_MIN  = 3,
  parameter int N_MAX  = 8,
  parameter int M1_MIN = 10,
  parameter int M1_MAX = 20,
  parameter int M2_MIN = 5,
  parameter int M2_MAX = 9,
  parameter int M_MIN  = 70,
  parameter int M_MAX  = 120,
  parameter int P1_MIN = 1,
  parameter int P1_MAX = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        valid,
  input logic        err,
  input logic [2:0]  mult_o,
  input logic [7:0]  n_o,
  input logic [7:0]  m1_o,
  input logic [7:0]  m2_o,
  input logic [7:0]  p1_o,
  input logic [23:0] div_word,
  input logic [31:0] found_hz
);

  logic [11:0] m_sum;
  assign m_sum = 12'd5 * {4'd0, m1_o} + {4'd0, m2_o};

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({valid, err, mult_o, n_o, m1_o, m2_o, p1_o, div_word, found_hz}));

  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (m1_o > m2_o) && (n_o >= 8'(N_MIN)) && (n_o <= 8'(N_MAX))
              && (m1_o >= 8'(M1_MIN)) && (m1_o <= 8'(M1_MAX))
              && (m2_o >= 8'(M2_MIN)) && (m2_o <= 8'(M2_MAX))
              && (p1_o >= 8'(P1_MIN)) && (p1_o <= 8'(P1_MAX))
              && (m_sum >= 12'(M_MIN)) && (m_sum <= 12'(M_MAX)));

  p_err_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !valid && (div_word == 24'd0) && (mult_o == 3'd0));

  p_mult_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($countones(mult_o) == 1) && !mult_o[0] || (mult_o == 3'd1));

  p_none_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (n_o == 8'd0) && (div_word == 24'd0) && (found_hz == 32'd0));

endmodule

bind pll_div_search pll_div_search_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .valid(valid), .err(err), .mult_o(mult_o), .n_o(n_o), .m1_o(m1_o),
  .m2_o(m2_o), .p1_o(p1_o), .div_word(div_word), .found_hz(found_hz)
);

// File: tb/pll_div_search_tb.sv
module pll_div_search_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic        clk = 1'b0;
  logic        rst_n, start;
  logic [31:0] pix_hz;
  logic        busy, done, valid, err;
  logic [2:0]  mult_o;
  logic [7:0]  n_o, m1_o, m2_o, p1_o;
  logic [23:0] div_word;
  logic [31:0] found_hz;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_div_search u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_hz(pix_hz),
    .busy(busy), .done(done), .valid(valid), .err(err), .mult_o(mult_o),
    .n_o(n_o), .m1_o(m1_o), .m2_o(m2_o), .p1_o(p1_o),
    .div_word(div_word), .found_hz(found_hz)
  );

  task automatic chk(input string req, input string what, input longint got, input longint exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  // behavioural search written from R3..R10
  task automatic model(input longint pix, output bit v, output bit e, output longint mult,
                       output longint bn, output longint bm1, output longint bm2,
                       output longint bp1, output longint hz);
    longint tgt, bd, mm, pp, vco, dot;
    bit stop;
    v = 0; e = 0; bn = 0; bm1 = 0; bm2 = 0; bp1 = 0; hz = 0; stop = 0;
    if (pix < 25000000) begin e = 1; mult = 0; return; end
    mult = (pix >= 100000000) ? 1 : (pix >= 50000000) ? 2 : 4;
    tgt = pix * mult;
    bd = 64'hFFFFFFFF;
    for (int n = 3; n <= 8 && !stop; n++)
      for (int m1 = 20; m1 >= 10 && !stop; m1--)
        for (int m2 = 9; m2 >= 5 && !stop; m2--)
          for (int p1 = 8; p1 >= 1 && !stop; p1--) begin
            mm = 5*m1 + m2;
            pp = p1 * 10;
            if (m1 <= m2 || mm < 70 || mm > 120 || pp < 5 || pp > 80) continue;
            vco = (64'd96000000 * mm) / n;
            dot = vco / pp;
            if (vco < 64'd1400000000 || vco > 64'd2800000000) continue;
            if (dot < 20000000 || dot > 400000000) continue;
            if (dot == tgt || (dot > tgt && dot - tgt < bd)) begin
              v = 1; bn = n; bm1 = m1; bm2 = m2; bp1 = p1; hz = dot; bd = dot - tgt;
              if (dot == tgt) stop = 1;
            end
          end
  endtask

  task automatic launch(input logic [31:0] pix);
    @(negedge clk);
    pix_hz = pix;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    chk("R2", "busy after start", busy, 1);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    chk("R11", "busy in done cycle", busy, 0);
  endtask

  task automatic compare(input longint pix, input string tag);
    bit v, e;
    longint mult, bn, bm1, bm2, bp1, hz, word;
    model(pix, v, e, mult, bn, bm1, bm2, bp1, hz);
    word = v ? (((bn - 2) << 16) | ((bm1 - 2) << 8) | (bm2 - 2)) : 0;
    chk(tag, "valid", valid, v);
    chk("R4", "err", err, e);
    chk("R3", "mult_o", mult_o, mult);
    chk(tag, "n_o", n_o, bn);
    chk(tag, "m1_o", m1_o, bm1);
    chk(tag, "m2_o", m2_o, bm2);
    chk(tag, "p1_o", p1_o, bp1);
    chk("R9", "div_word", div_word, word);
    chk("R10", "found_hz", found_hz, hz);
  endtask

  task automatic finish_check();
    @(negedge clk);
    chk("R11", "done single cycle", done, 0);
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "valid", valid, 0);
    chk("R1", "err", err, 0);
    chk("R1", "div_word", div_word, 0);
    chk("R1", "found_hz", found_hz, 0);
    chk("R1", "n_o", n_o, 0);
  endtask

  task automatic t_exact();
    launch(32'd108000000);
    wait_done();
    compare(108000000, "R6");
    chk("R6", "exact n", n_o, 4);
    chk("R6", "exact m1", m1_o, 17);
    chk("R6", "exact m2", m2_o, 5);
    chk("R6", "exact p1", p1_o, 2);
    chk("R9", "exact word", div_word, 24'h020F03);
    chk("R10", "exact hz", found_hz, 108000000);
    finish_check();
  endtask

  task automatic t_busy_ignore();
    int extra;
    launch(32'd108000000);
    repeat (5) @(negedge clk);
    pix_hz = 32'd300000000;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    chk("R2", "still busy", busy, 1);
    wait_done();
    compare(108000000, "R2");
    finish_check();
    extra = 0;
    repeat (40) begin @(negedge clk); if (done) extra++; end
    chk("R2", "no extra done", extra, 0);
    chk("R2", "idle after", busy, 0);
  endtask

  task automatic t_hold();
    logic [23:0] w;
    logic [31:0] h;
    w = div_word;
    h = found_hz;
    pix_hz = 32'd65000000;
    repeat (10) @(negedge clk);
    chk("R11", "word held", div_word, w);
    chk("R11", "hz held", found_hz, h);
    chk("R11", "no done while idle", done, 0);
  endtask

  task automatic t_search(input logic [31:0] pix, input string tag);
    launch(pix);
    wait_done();
    compare(pix, tag);
    finish_check();
  endtask

  task automatic t_error();
    launch(32'd24999999);
    wait_done();
    chk("R4", "err", err, 1);
    chk("R4", "valid", valid, 0);
    chk("R4", "mult_o", mult_o, 0);
    chk("R4", "div_word", div_word, 0);
    chk("R4", "found_hz", found_hz, 0);
    finish_check();
  endtask

  task automatic t_none();
    launch(32'd300000000);
    wait_done();
    chk("R8", "valid", valid, 0);
    chk("R8", "err", err, 0);
    chk("R8", "mult_o", mult_o, 1);
    chk("R8", "n_o", n_o, 0);
    chk("R8", "div_word", div_word, 0);
    chk("R8", "found_hz", found_hz, 0);
    finish_check();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; pix_hz = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_hold();
    t_busy_ignore();
    t_error();
    t_search(32'd25000000, "R7");
    t_search(32'd50000000, "R7");
    t_search(32'd99999999, "R7");
    t_search(32'd100000000, "R5");
    t_search(32'd65000000, "R7");
    t_none();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule